// File: doc/BRIEF.md
# Threaded-Sense ROM Word Readout

This block models the read path of a fixed-program store laid out like a woven rope memory. A flat word address is split into three fields: one picks a core, one picks a strand, and one picks a module. Each core location carries a wide vector of sense bits, one bit per sense wire. A bit is 1 where the wire threads the core and 0 where the wire passes around it. The vector is cut into strands of sixteen bits. The addressed strand becomes the word: fifteen data bits and one parity bit, all read in parallel.

The stored contents are fixed. A seed parameter and a stride parameter set them arithmetically, so a full-size store needs no stored table. Every word carries odd parity, except at a regular stride of flat indices where the parity bit is stored inverted. Those words model a mis-threaded wire. A client raises a read request with an address. Two cycles later it sees a valid strobe with the data word, a parity-error flag and an out-of-range flag. Requests may be issued back to back, one per cycle.

Top module: `rope_word_reader`

## Requirements
- R1: The address is split as core = bits [8:0], strand = bits [12:9] and module = bits [15:13]. The flat word index is module*6144 + strand*512 + core, for 12 strands per core, 512 cores per module and 6 modules.
- R2: The stored word at flat index n has data equal to the low 15 bits of n*40503, XOR the seed 0x1B3D. Its parity bit (bit 15) gives the 16-bit word an odd number of ones, except when n is a multiple of 97; there the parity bit is inverted.
- R3: A request sampled at a rising edge produces exactly one valid cycle, two rising edges later. A cycle without a request produces no valid two edges later. Requests on consecutive cycles are all served in order.
- R4: A strand field above 11 or a module field above 5 raises the out-of-range flag with valid. In that case the data output is zero and the parity-error flag is low.
- R5: For an in-range read, the parity-error flag is high with valid exactly when the 16-bit stored word has an even number of ones.
- R6: When valid is low, both flags are low and the data output keeps the value of the last read.
- R7: Reading the same address again returns the same data and flags as before; a read does not change the contents.
- R8: While reset is asserted, valid, both flags and the data output are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_req_i | input | 1 | Read request, sampled each rising edge |
| rd_addr_i | input | 16 | Word address: module, strand and core fields |
| rd_data_o | output | 15 | Data bits of the word that was read |
| par_err_o | output | 1 | Stored word fails odd parity, high with valid |
| oor_o | output | 1 | Strand or module field out of range, high with valid |
| rd_valid_o | output | 1 | One-cycle strobe, two cycles after the request |

## Verification
If a request is lost or duplicated in the pipeline, the valid strobe appears missing or extra two cycles later. If a field is latched wrongly, the next valid carries data for a different flat index. If the strand select is wrong, the wrong slice of the core vector shows up as a data mismatch at the same point. A parity computed over the wrong bits shows as a wrong parity flag on the stride words. The bench reads every one of the 65,536 address codes back to back. Each fault therefore shows at the ports within two cycles of the first request that touches it.

// File: rtl/rope_pkg.sv
package rope_pkg;

  localparam int unsigned DATA_W   = 15;
  localparam int unsigned WORD_W   = DATA_W + 1;
  localparam int unsigned MIX_MULT = 40503;

  // Woven content of one strand word: data from a multiplicative mix of the
  // flat index, parity bit on top giving odd weight unless the index hits
  // the mis-thread stride.
  function automatic logic [WORD_W-1:0] woven_word(
    input int unsigned        idx,
    input logic [DATA_W-1:0]  seed,
    input int unsigned        stride
  );
    logic [DATA_W-1:0] dat;
    logic              par;
    dat = DATA_W'(idx * MIX_MULT) ^ seed;
    par = ~(^dat);
    if ((idx % stride) == 0) par = ~par;
    return {par, dat};
  endfunction

endpackage

// File: rtl/rope_rst_sync.sv
module rope_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) stage_q <= '0;
    else          stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_o = stage_q[1];

endmodule

// File: rtl/rope_addr_split.sv
module rope_addr_split #(
  parameter int unsigned CORES    = 512,
  parameter int unsigned STRANDS  = 12,
  parameter int unsigned MODULES  = 6,
  localparam int unsigned CORE_W   = $clog2(CORES),
  localparam int unsigned STRAND_W = $clog2(STRANDS),
  localparam int unsigned MOD_W    = $clog2(MODULES),
  localparam int unsigned ADDR_W   = CORE_W + STRAND_W + MOD_W
) (
  input  logic [ADDR_W-1:0]   addr_i,
  output logic [CORE_W-1:0]   core_o,
  output logic [STRAND_W-1:0] strand_o,
  output logic [MOD_W-1:0]    mod_o,
  output logic                oor_o
);

  assign core_o   = addr_i[CORE_W-1:0];
  assign strand_o = addr_i[CORE_W +: STRAND_W];
  assign mod_o    = addr_i[CORE_W+STRAND_W +: MOD_W];

  always_comb begin
    oor_o = (32'(strand_o) >= STRANDS) || (32'(mod_o) >= MODULES);
  end

endmodule

// File: rtl/rope_core_array.sv
module rope_core_array
  import rope_pkg::*;
#(
  parameter int unsigned       CORES      = 512,
  parameter int unsigned       STRANDS    = 12,
  parameter int unsigned       MODULES    = 6,
  parameter logic [DATA_W-1:0] SEED       = 15'h1B3D,
  parameter int unsigned       BAD_STRIDE = 97,
  localparam int unsigned CORE_W   = $clog2(CORES),
  localparam int unsigned MOD_W    = $clog2(MODULES),
  localparam int unsigned SENSE_W  = STRANDS * WORD_W,
  localparam int unsigned MOD_SPAN = STRANDS * CORES
) (
  input  logic [MOD_W-1:0]   mod_i,
  input  logic [CORE_W-1:0]  core_i,
  output logic [SENSE_W-1:0] sense_o
);

  // One slice of the core's sense vector per strand; the whole vector is
  // presented at once, as every wire through the core responds together.
  for (genvar s = 0; s < STRANDS; s++) begin : g_strand
    localparam int unsigned BASE = s * CORES;
    logic [31:0] flat_idx;
    assign flat_idx = 32'(mod_i) * MOD_SPAN + BASE + 32'(core_i);
    assign sense_o[s*WORD_W +: WORD_W] = woven_word(flat_idx, SEED, BAD_STRIDE);
  end

endmodule

// File: rtl/rope_strand_mux.sv
module rope_strand_mux
  import rope_pkg::*;
#(
  parameter int unsigned STRANDS = 12,
  localparam int unsigned STRAND_W = $clog2(STRANDS),
  localparam int unsigned SENSE_W  = STRANDS * WORD_W
) (
  input  logic [SENSE_W-1:0]  sense_i,
  input  logic [STRAND_W-1:0] strand_i,
  output logic [WORD_W-1:0]   word_o
);

  always_comb begin
    word_o = '0;
    for (int s = 0; s < STRANDS; s++) begin
      if (strand_i == STRAND_W'(s)) word_o = sense_i[s*WORD_W +: WORD_W];
    end
  end

endmodule

// File: rtl/rope_word_reader.sv
module rope_word_reader
  import rope_pkg::*;
#(
  parameter int unsigned       CORES      = 512,
  parameter int unsigned       STRANDS    = 12,
  parameter int unsigned       MODULES    = 6,
  parameter logic [DATA_W-1:0] SEED       = 15'h1B3D,
  parameter int unsigned       BAD_STRIDE = 97,
  localparam int unsigned CORE_W   = $clog2(CORES),
  localparam int unsigned STRAND_W = $clog2(STRANDS),
  localparam int unsigned MOD_W    = $clog2(MODULES),
  localparam int unsigned ADDR_W   = CORE_W + STRAND_W + MOD_W,
  localparam int unsigned SENSE_W  = STRANDS * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              par_err_o,
  output logic              oor_o,
  output logic              rd_valid_o
);

  logic rst_n_int;

  rope_rst_sync i_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_int)
  );

  // ---------------- stage 1: address capture ----------------
  logic [CORE_W-1:0]   dec_core;
  logic [STRAND_W-1:0] dec_strand;
  logic [MOD_W-1:0]    dec_mod;
  logic                dec_oor;

  rope_addr_split #(
    .CORES   (CORES),
    .STRANDS (STRANDS),
    .MODULES (MODULES)
  ) i_addr_split (
    .addr_i   (rd_addr_i),
    .core_o   (dec_core),
    .strand_o (dec_strand),
    .mod_o    (dec_mod),
    .oor_o    (dec_oor)
  );

  logic                s1_vld_q,    s1_vld_d;
  logic [CORE_W-1:0]   s1_core_q,   s1_core_d;
  logic [STRAND_W-1:0] s1_strand_q, s1_strand_d;
  logic [MOD_W-1:0]    s1_mod_q,    s1_mod_d;
  logic                s1_oor_q,    s1_oor_d;
  logic                s1_en;

  always_comb begin
    s1_en       = rd_req_i;
    s1_vld_d    = rd_req_i;
    s1_core_d   = dec_core;
    s1_strand_d = dec_strand;
    s1_mod_d    = dec_mod;
    s1_oor_d    = dec_oor;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      s1_vld_q    <= 1'b0;
      s1_core_q   <= '0;
      s1_strand_q <= '0;
      s1_mod_q    <= '0;
      s1_oor_q    <= 1'b0;
    end else begin
      s1_vld_q <= s1_vld_d;
      if (s1_en) begin
        s1_core_q   <= s1_core_d;
        s1_strand_q <= s1_strand_d;
        s1_mod_q    <= s1_mod_d;
        s1_oor_q    <= s1_oor_d;
      end
    end
  end

  // ---------------- sense vector and strand select ----------------
  logic [SENSE_W-1:0] sense_vec;
  logic [WORD_W-1:0]  sel_word;

  rope_core_array #(
    .CORES      (CORES),
    .STRANDS    (STRANDS),
    .MODULES    (MODULES),
    .SEED       (SEED),
    .BAD_STRIDE (BAD_STRIDE)
  ) i_core_array (
    .mod_i   (s1_mod_q),
    .core_i  (s1_core_q),
    .sense_o (sense_vec)
  );

  rope_strand_mux #(
    .STRANDS (STRANDS)
  ) i_strand_mux (
    .sense_i  (sense_vec),
    .strand_i (s1_strand_q),
    .word_o   (sel_word)
  );

  // ---------------- stage 2: output register ----------------
  logic              out_vld_d,  out_vld_q;
  logic [DATA_W-1:0] out_data_d, out_data_q;
  logic              out_perr_d, out_perr_q;
  logic              out_oor_d,  out_oor_q;
  logic              out_en;
  logic              word_even;

  always_comb begin
    word_even  = ~(^sel_word);
    out_en     = s1_vld_q;
    out_vld_d  = s1_vld_q;
    out_data_d = s1_oor_q ? '0 : sel_word[DATA_W-1:0];
    out_perr_d = s1_vld_q & ~s1_oor_q & word_even;
    out_oor_d  = s1_vld_q & s1_oor_q;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      out_vld_q  <= 1'b0;
      out_data_q <= '0;
      out_perr_q <= 1'b0;
      out_oor_q  <= 1'b0;
    end else begin
      out_vld_q  <= out_vld_d;
      out_perr_q <= out_perr_d;
      out_oor_q  <= out_oor_d;
      if (out_en) out_data_q <= out_data_d;
    end
  end

  assign rd_data_o  = out_data_q;
  assign par_err_o  = out_perr_q;
  assign oor_o      = out_oor_q;
  assign rd_valid_o = out_vld_q;

endmodule

// File: rtl/rope_word_reader_chk.sv
module rope_word_reader_chk #(
  parameter int unsigned CORES   = 512,
  parameter int unsigned STRANDS = 12,
  parameter int unsigned MODULES = 6,
  parameter int unsigned DATA_W  = 15,
  localparam int unsigned CORE_W   = $clog2(CORES),
  localparam int unsigned STRAND_W = $clog2(STRANDS),
  localparam int unsigned MOD_W    = $clog2(MODULES),
  localparam int unsigned ADDR_W   = CORE_W + STRAND_W + MOD_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_req_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              par_err_o,
  input logic              oor_o,
  input logic              rd_valid_o
);

  logic req_bad_range;
  assign req_bad_range = (32'(rd_addr_i[CORE_W +: STRAND_W]) >= STRANDS) ||
                         (32'(rd_addr_i[CORE_W+STRAND_W +: MOD_W]) >= MODULES);

  AST_REQ_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_i |-> ##2 rd_valid_o); // R3

  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req_i |-> ##2 !rd_valid_o); // R3

  AST_RANGE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_i && req_bad_range) |-> ##2 oor_o); // R4

  AST_IN_RANGE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_i && !req_bad_range) |-> ##2 !oor_o); // R4

  AST_OOR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    oor_o |-> (rd_data_o == '0 && !par_err_o)); // R4

  AST_FLAGS_NEED_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (par_err_o || oor_o) |-> rd_valid_o); // R6

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid_o |-> $stable(rd_data_o)); // R6

endmodule

bind rope_word_reader rope_word_reader_chk #(
  .CORES   (CORES),
  .STRANDS (STRANDS),
  .MODULES (MODULES),
  .DATA_W  (rope_pkg::DATA_W)
) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_req_i   (rd_req_i),
  .rd_addr_i  (rd_addr_i),
  .rd_data_o  (rd_data_o),
  .par_err_o  (par_err_o),
  .oor_o      (oor_o),
  .rd_valid_o (rd_valid_o)
);

// File: tb/test_rope_word_reader.sv
`timescale 1ns/1ps
module test_rope_word_reader;

  localparam int SEED   = 'h1B3D;
  localparam int STRIDE = 97;

  logic        clk;
  logic        rst_n;
  logic        rd_req;
  logic [15:0] rd_addr;
  logic [14:0] rd_data;
  logic        par_err;
  logic        oor;
  logic        rd_valid;

  rope_word_reader i_rope_word_reader (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_req_i   (rd_req),
    .rd_addr_i  (rd_addr),
    .rd_data_o  (rd_data),
    .par_err_o  (par_err),
    .oor_o      (oor),
    .rd_valid_o (rd_valid)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks;
  int fails;
  bit done;

  logic        p0_req, p1_req;
  logic [15:0] p0_addr, p1_addr;
  logic [14:0] last_data;
  bit          have_prev;
  logic [15:0] prev_addr;
  logic [14:0] prev_data;
  logic        prev_perr;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual 0x%0h expected 0x%0h", tag, $time, act, exp);
    end
  endtask

  // Expected word from the address arithmetic of R1 and R2.
  task automatic expect_word(input logic [15:0] a, output bit e_oor,
                             output int e_data, output bit e_perr);
    int core, strand, modl, n, ones, par;
    core   = int'(a[8:0]);
    strand = int'(a[12:9]);
    modl   = int'(a[15:13]);
    e_oor  = (strand > 11) || (modl > 5);
    if (e_oor) begin
      e_data = 0;
      e_perr = 1'b0;
    end else begin
      n      = modl * 6144 + strand * 512 + core;
      e_data = ((n * 40503) & 32'h7FFF) ^ SEED;
      ones   = $countones(e_data[14:0]);
      par    = (ones % 2 == 0) ? 1 : 0;
      if (n % STRIDE == 0) par = 1 - par;
      e_perr = ((ones + par) % 2) == 0;
    end
  endtask

  task automatic check_out();
    bit e_oor, e_perr;
    int e_data;
    if (p1_req) begin
      expect_word(p1_addr, e_oor, e_data, e_perr);
      chk(rd_valid == 1'b1, "R3", int'(rd_valid), 1);
      chk(oor == e_oor, "R4", int'(oor), int'(e_oor));
      if (e_oor) chk(int'(rd_data) == e_data, "R4", int'(rd_data), e_data);
      else       chk(int'(rd_data) == e_data, "R1/R2", int'(rd_data), e_data);
      if (e_oor) chk(par_err == e_perr, "R4", int'(par_err), int'(e_perr));
      else       chk(par_err == e_perr, "R5", int'(par_err), int'(e_perr));
      if (have_prev && p1_addr == prev_addr) begin
        chk(rd_data == prev_data, "R7", int'(rd_data), int'(prev_data));
        chk(par_err == prev_perr, "R7", int'(par_err), int'(prev_perr));
      end
      have_prev = 1'b1;
      prev_addr = p1_addr;
      prev_data = rd_data;
      prev_perr = par_err;
      last_data = e_data[14:0];
    end else begin
      chk(rd_valid == 1'b0, "R3", int'(rd_valid), 0);
      chk(!par_err && !oor, "R6", int'({par_err, oor}), 0);
      chk(rd_data == last_data, "R6", int'(rd_data), int'(last_data));
    end
  endtask

  task automatic step(input logic req, input logic [15:0] addr);
    @(negedge clk);
    check_out();
    p1_req  = p0_req;
    p1_addr = p0_addr;
    p0_req  = req;
    p0_addr = addr;
    rd_req  = req;
    rd_addr = addr;
  endtask

  initial begin
    checks = 0; fails = 0; done = 1'b0;
    p0_req = 0; p1_req = 0; p0_addr = '0; p1_addr = '0;
    last_data = '0; have_prev = 0;
    prev_addr = '0; prev_data = '0; prev_perr = 1'b0;
    rst_n = 1'b0; rd_req = 1'b0; rd_addr = '0;

    // R8: outputs during reset
    repeat (3) @(negedge clk);
    chk(rd_valid == 1'b0, "R8", int'(rd_valid), 0);
    chk(!par_err && !oor, "R8", int'({par_err, oor}), 0);
    chk(rd_data == '0, "R8", int'(rd_data), 0);
    rst_n = 1'b1;
    repeat (5) step(1'b0, 16'h0);

    // Full back-to-back sweep of every address code (R1 R2 R3 R4 R5)
    for (int a = 0; a < 65536; a++) step(1'b1, 16'(a));
    repeat (3) step(1'b0, 16'h0);

    // Sparse requests with idle gaps (R3 R6)
    for (int i = 0; i < 300; i++) begin
      step(1'b1, 16'((i * 331 + 17) % 65536));
      repeat (1 + i % 3) step(1'b0, 16'hFFFF);
    end

    // Repeated reads of one address (R7): a stride word and a plain word
    repeat (5) step(1'b1, 16'd97);
    step(1'b0, 16'h0);
    repeat (4) step(1'b1, {3'd4, 4'd11, 9'd300});
    step(1'b0, 16'h0);
    repeat (3) step(1'b1, {3'd7, 4'd2, 9'd5});
    repeat (4) step(1'b0, 16'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule